// File: doc/BRIEF.md
# Supply Supervisor Reset Controller with Bus-Start Watchdog

This block is the digital core of a CPU supervisor. It holds a reset output active while the supply is low and for a fixed settling time after the supply recovers. It also asserts reset when the processor stops showing signs of activity. Activity is a start condition on a two-wire serial bus: the data line falls while the clock line is high. The supply comparison itself is done elsewhere. The block only sees a synchronous supply-good level.

All delays are counted in clock cycles, with the parameter `CYC_PER_MS` giving the number of cycles in one millisecond. The settling time is `RST_MS`. The watchdog period is chosen by a two-bit field, and that field cannot be written while the write-protect input is high.

Reset also guards a companion serial memory interface. When reset rises, the block pulses an abort strobe that cancels the bus transaction in progress. No new internal nonvolatile write may begin while reset is active. A write that has already started is left running until it reports completion.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `porN` is low, `resetOut` is 1, `wdPeriodSel` is 00, `busAbort` is 0 and `nvWrBusy` is 0. Release `porN` with `supplyOk` held high. `resetOut` then falls at the RST_MS*CYC_PER_MS-th rising clock edge that follows.
- R2: If `supplyOk` is 0 at a rising edge, `resetOut` is 1 after that edge.
- R3: After a supply loss, `resetOut` falls only after `supplyOk` has been 1 for RST_MS*CYC_PER_MS consecutive edges. Any edge with `supplyOk` at 0 restarts this count.
- R4: A start condition restarts the watchdog count. A start condition is a fall of the synchronised SDA while the synchronised SCL is high both in that cycle and in the cycle before. Inputs pass two synchronising flops, so the count restarts three edges after the SDA input falls.
- R5: An SDA fall is not a start condition if SCL is low at the fall, or if SCL rises in the same synchronised cycle as the fall.
- R6: Without a start condition, `resetOut` rises after the watchdog period, counted from its release. `wdPeriodSel` selects the period: 00 = WD_LONG_MS, 01 = WD_MID_MS, 10 = WD_SHORT_MS, each multiplied by CYC_PER_MS cycles. 11 turns the watchdog off.
- R7: A watchdog time-out holds `resetOut` high for RST_MS*CYC_PER_MS cycles when `supplyOk` stays high. The watchdog count is held at zero while reset is active.
- R8: When `wdWrEn` is 1 and `wrProtect` is 0, `wdPeriodSel` takes `wdWrData` at the next edge. When `wrProtect` is 1, `wdPeriodSel` does not change.
- R9: `busAbort` is a one-cycle pulse that rises together with `resetOut`, whatever the cause of the reset. `resetOut` high is the inhibit for new bus transactions.
- R10: `nvWrBusy` goes to 1 one edge after `nvWrReq`, but only when `resetOut` is 0. It returns to 0 one edge after `nvWrDone`. A write that is running stays running when reset asserts, and a request made while reset is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| porN | input | 1 | Asynchronous power-on clear of the logic, active low |
| supplyOk | input | 1 | Digitised supply-above-trip level, synchronous |
| sclIn | input | 1 | Serial bus clock line, asynchronous |
| sdaIn | input | 1 | Serial bus data line, asynchronous |
| wdWrEn | input | 1 | Write strobe for the watchdog period field |
| wdWrData | input | 2 | New value for the watchdog period field |
| wrProtect | input | 1 | Locks the watchdog period field when high |
| nvWrReq | input | 1 | Request to start an internal nonvolatile write |
| nvWrDone | input | 1 | Completion of the running nonvolatile write |
| resetOut | output | 1 | Active-high reset and bus inhibit |
| busAbort | output | 1 | One-cycle abort of the serial transaction in progress |
| wdPeriodSel | output | 2 | Current watchdog period field |
| nvWrBusy | output | 1 | Nonvolatile write in progress |

## Verification
The checker watches several rules on every cycle:
- a low supply forces reset at the next edge;
- reset is released only with the supply good;
- the abort pulse coincides with the rise of reset;
- the period field is frozen under write protect;
- no write starts during reset, and a running write survives it.

Only the bench scenarios can show the exact cycle counts. These are the settling delay, the restart of that delay by a dip, the three watchdog periods and the disabled code, the exact three-edge shift of a time-out caused by a valid start, and the rejection of the two look-alike SCL/SDA patterns.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} supvState_e;

  typedef struct packed {
    logic dlyInc;
    logic wdInc;
    logic wdClr;
    logic enterHold;
  } supvStrobe_t;

  localparam logic [1:0] WD_CODE_LONG  = 2'b00;
  localparam logic [1:0] WD_CODE_MID   = 2'b01;
  localparam logic [1:0] WD_CODE_SHORT = 2'b10;
  localparam logic [1:0] WD_CODE_OFF   = 2'b11;
endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stage1 <= RESET_VAL;
      dout   <= RESET_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int CYC_PER_MS  = 32,
  parameter int RST_MS      = 200,
  parameter int WD_LONG_MS  = 1400,
  parameter int WD_MID_MS   = 600,
  parameter int WD_SHORT_MS = 200
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        supplyOk,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        wdWrEn,
  input  logic [1:0]  wdWrData,
  input  logic        wrProtect,
  input  logic        nvWrReq,
  input  logic        nvWrDone,
  input  supvStrobe_t strobe,
  input  logic        holdActive,
  output logic        dlyDone,
  output logic        wdExpire,
  output logic        wdEnabled,
  output logic        startSeen,
  output logic [1:0]  wdSel,
  output logic        busAbort,
  output logic        nvWrBusy
);
  localparam int RST_CYC   = RST_MS * CYC_PER_MS;
  localparam int LONG_CYC  = WD_LONG_MS * CYC_PER_MS;
  localparam int MID_CYC   = WD_MID_MS * CYC_PER_MS;
  localparam int SHORT_CYC = WD_SHORT_MS * CYC_PER_MS;
  localparam int MAX_A     = (LONG_CYC > MID_CYC) ? LONG_CYC : MID_CYC;
  localparam int MAX_B     = (MAX_A > SHORT_CYC) ? MAX_A : SHORT_CYC;
  localparam int MAX_CYC   = (MAX_B > RST_CYC) ? MAX_B : RST_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] MID_LAST   = CNT_W'(MID_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

  // Bus line synchronisation and start detection
  logic [1:0] busSync;
  logic       sclPrev;
  logic       sdaPrev;
  logic       sclNow;
  logic       sdaNow;

  supv_sync2 #(.WIDTH(2), .RESET_VAL(2'b11)) busSync_i (
    .clk  (clk),
    .porN (porN),
    .din  ({sclIn, sdaIn}),
    .dout (busSync)
  );

  assign sclNow = busSync[1];
  assign sdaNow = busSync[0];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;

  // Watchdog period field
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdSel <= WD_CODE_LONG;
    end else if (wdWrEn && !wrProtect) begin
      wdSel <= wdWrData;
    end
  end

  logic [CNT_W-1:0] wdLast;

  always_comb begin
    unique case (wdSel)
      WD_CODE_LONG:  wdLast = LONG_LAST;
      WD_CODE_MID:   wdLast = MID_LAST;
      WD_CODE_SHORT: wdLast = SHORT_LAST;
      default:       wdLast = LONG_LAST;
    endcase
  end

  assign wdEnabled = (wdSel != WD_CODE_OFF);

  // Settling-delay counter
  logic [CNT_W-1:0] dlyCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      dlyCnt <= '0;
    end else if (strobe.dlyInc) begin
      dlyCnt <= dlyCnt + 1'b1;
    end else begin
      dlyCnt <= '0;
    end
  end

  assign dlyDone = supplyOk && (dlyCnt == RST_LAST);

  // Watchdog counter
  logic [CNT_W-1:0] wdCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdCnt <= '0;
    end else if (strobe.wdClr) begin
      wdCnt <= '0;
    end else if (strobe.wdInc) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign wdExpire = wdEnabled && !startSeen && (wdCnt >= wdLast);

  // Bus abort pulse and nonvolatile write tracking
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busAbort <= 1'b0;
    end else begin
      busAbort <= strobe.enterHold;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      nvWrBusy <= 1'b0;
    end else if (nvWrBusy) begin
      if (nvWrDone) nvWrBusy <= 1'b0;
    end else if (nvWrReq && !holdActive) begin
      nvWrBusy <= 1'b1;
    end
  end
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        supplyOk,
  input  logic        dlyDone,
  input  logic        wdExpire,
  input  logic        wdEnabled,
  input  logic        startSeen,
  output supvStrobe_t strobe,
  output logic        holdActive
);
  supvState_e state;
  supvState_e stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  assign holdActive = (state == ST_HOLD);

  always_comb begin
    stateNext        = state;
    strobe.dlyInc    = 1'b0;
    strobe.enterHold = 1'b0;
    strobe.wdClr     = holdActive || startSeen || !wdEnabled;
    strobe.wdInc     = !strobe.wdClr;
    unique case (state)
      ST_HOLD: begin
        strobe.dlyInc = supplyOk;
        if (dlyDone) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (!supplyOk || wdExpire) begin
          stateNext        = ST_HOLD;
          strobe.enterHold = 1'b1;
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int CYC_PER_MS  = 32,
  parameter int RST_MS      = 200,
  parameter int WD_LONG_MS  = 1400,
  parameter int WD_MID_MS   = 600,
  parameter int WD_SHORT_MS = 200
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       supplyOk,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wdWrEn,
  input  logic [1:0] wdWrData,
  input  logic       wrProtect,
  input  logic       nvWrReq,
  input  logic       nvWrDone,
  output logic       resetOut,
  output logic       busAbort,
  output logic [1:0] wdPeriodSel,
  output logic       nvWrBusy
);
  supvStrobe_t strobe;
  logic holdActive;
  logic dlyDone;
  logic wdExpire;
  logic wdEnabled;
  logic startSeen;

  supv_control control_i (
    .clk        (clk),
    .porN       (porN),
    .supplyOk   (supplyOk),
    .dlyDone    (dlyDone),
    .wdExpire   (wdExpire),
    .wdEnabled  (wdEnabled),
    .startSeen  (startSeen),
    .strobe     (strobe),
    .holdActive (holdActive)
  );

  supv_datapath #(
    .CYC_PER_MS  (CYC_PER_MS),
    .RST_MS      (RST_MS),
    .WD_LONG_MS  (WD_LONG_MS),
    .WD_MID_MS   (WD_MID_MS),
    .WD_SHORT_MS (WD_SHORT_MS)
  ) datapath_i (
    .clk        (clk),
    .porN       (porN),
    .supplyOk   (supplyOk),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .wdWrEn     (wdWrEn),
    .wdWrData   (wdWrData),
    .wrProtect  (wrProtect),
    .nvWrReq    (nvWrReq),
    .nvWrDone   (nvWrDone),
    .strobe     (strobe),
    .holdActive (holdActive),
    .dlyDone    (dlyDone),
    .wdExpire   (wdExpire),
    .wdEnabled  (wdEnabled),
    .startSeen  (startSeen),
    .wdSel      (wdPeriodSel),
    .busAbort   (busAbort),
    .nvWrBusy   (nvWrBusy)
  );

  assign resetOut = holdActive;
endmodule

// File: rtl/supv_checker.sv
module supv_checker (
  input logic       clk,
  input logic       porN,
  input logic       supplyOk,
  input logic       wrProtect,
  input logic       nvWrDone,
  input logic       resetOut,
  input logic       busAbort,
  input logic [1:0] wdPeriodSel,
  input logic       nvWrBusy
);
  p_supply_low_resets_r2: assert property (@(posedge clk) disable iff (!porN)
    !supplyOk |=> resetOut);

  p_release_needs_supply_r3: assert property (@(posedge clk) disable iff (!porN)
    $fell(resetOut) |-> $past(supplyOk));

  p_abort_with_reset_r9: assert property (@(posedge clk) disable iff (!porN)
    $rose(resetOut) |-> busAbort);

  p_abort_only_at_rise_r9: assert property (@(posedge clk) disable iff (!porN)
    busAbort |-> (resetOut && $rose(resetOut)));

  p_field_locked_r8: assert property (@(posedge clk) disable iff (!porN)
    wrProtect |=> $stable(wdPeriodSel));

  p_no_write_start_in_reset_r10: assert property (@(posedge clk) disable iff (!porN)
    (resetOut && !nvWrBusy) |=> !nvWrBusy);

  p_write_runs_to_end_r10: assert property (@(posedge clk) disable iff (!porN)
    (nvWrBusy && !nvWrDone) |=> nvWrBusy);
endmodule

bind supv_reset_ctrl supv_checker checker_i (
  .clk         (clk),
  .porN        (porN),
  .supplyOk    (supplyOk),
  .wrProtect   (wrProtect),
  .nvWrDone    (nvWrDone),
  .resetOut    (resetOut),
  .busAbort    (busAbort),
  .wdPeriodSel (wdPeriodSel),
  .nvWrBusy    (nvWrBusy)
);

// File: tb/supv_reset_ctrl_tb.sv
`timescale 1ns/1ps
module supv_reset_ctrl_tb_top;
  localparam int CPM       = 2;
  localparam int RST_CYC   = 200 * CPM;
  localparam int LONG_CYC  = 1400 * CPM;
  localparam int MID_CYC   = 600 * CPM;
  localparam int SHORT_CYC = 200 * CPM;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyOk = 1'b1;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic wdWrEn = 1'b0;
  logic [1:0] wdWrData = 2'b00;
  logic wrProtect = 1'b0;
  logic nvWrReq = 1'b0;
  logic nvWrDone = 1'b0;
  logic resetOut;
  logic busAbort;
  logic [1:0] wdPeriodSel;
  logic nvWrBusy;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  supv_reset_ctrl #(
    .CYC_PER_MS(CPM), .RST_MS(200), .WD_LONG_MS(1400), .WD_MID_MS(600), .WD_SHORT_MS(200)
  ) dut_i (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .sclIn(sclIn), .sdaIn(sdaIn),
    .wdWrEn(wdWrEn), .wdWrData(wdWrData), .wrProtect(wrProtect),
    .nvWrReq(nvWrReq), .nvWrDone(nvWrDone), .resetOut(resetOut),
    .busAbort(busAbort), .wdPeriodSel(wdPeriodSel), .nvWrBusy(nvWrBusy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic countLevel(input logic lvl, input int lim, output int n);
    n = 0;
    while (resetOut === lvl && n < lim) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitLow();
    while (resetOut !== 1'b0) @(negedge clk);
  endtask

  task automatic writeBits(input logic [1:0] v);
    wdWrEn = 1'b1;
    wdWrData = v;
    @(negedge clk);
    wdWrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int total;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset out", resetOut, 1);
    check("R1 field", wdPeriodSel, 0);
    check("R1 abort", busAbort, 0);
    check("R1 nv busy", nvWrBusy, 0);
    porN = 1'b1;
    @(negedge clk);
    countLevel(1'b1, 10000, n);
    check("R1 power-up hold", n, RST_CYC - 1);

    // R6 code 00, then R7 pulse and R9 abort
    countLevel(1'b0, 10000, n);
    check("R6 period 00", n, LONG_CYC);
    check("R9 abort at wd reset", busAbort, 1);
    countLevel(1'b1, 10000, n);
    check("R7 wd pulse length", n, RST_CYC);
    check("R9 abort one cycle", busAbort, 0);

    // R8 write then R6 code 01
    writeBits(2'b01);
    check("R8 write 01", wdPeriodSel, 1);
    countLevel(1'b0, 10000, n);
    check("R6 period 01", n, MID_CYC - 1);
    countLevel(1'b1, 10000, n);
    check("R7 pulse after 01", n, RST_CYC);

    writeBits(2'b10);
    check("R8 write 10", wdPeriodSel, 2);
    countLevel(1'b0, 10000, n);
    check("R6 period 10", n, SHORT_CYC - 1);
    countLevel(1'b1, 10000, n);

    writeBits(2'b11);
    check("R8 write 11", wdPeriodSel, 3);
    countLevel(1'b0, 3000, n);
    check("R6 disabled", n, 3000);

    // R8 lock sweep
    wrProtect = 1'b1;
    for (int v = 0; v < 4; v++) begin
      writeBits(v[1:0]);
      check("R8 locked field", wdPeriodSel, 3);
    end
    check("R6 disabled under lock", resetOut, 0);
    wrProtect = 1'b0;
    writeBits(2'b10);
    check("R8 unlocked write", wdPeriodSel, 2);

    // R2 brown-out, R9 abort, R3 dip restart
    supplyOk = 1'b0;
    @(negedge clk);
    check("R2 reset on supply loss", resetOut, 1);
    check("R9 abort on supply loss", busAbort, 1);
    repeat (5) @(negedge clk);
    check("R2 held while low", resetOut, 1);
    supplyOk = 1'b1;
    repeat (100) @(negedge clk);
    check("R3 still held mid-delay", resetOut, 1);
    supplyOk = 1'b0;
    @(negedge clk);
    supplyOk = 1'b1;
    @(negedge clk);
    countLevel(1'b1, 10000, n);
    check("R3 delay restarted by dip", n, RST_CYC - 1);

    // R4 valid start condition at sample 300
    repeat (299) @(negedge clk);
    sdaIn = 1'b0;
    repeat (2) @(negedge clk);
    sdaIn = 1'b1;
    countLevel(1'b0, 10000, n);
    total = 301 + n;
    check("R4 start restarts count", total, 300 + 2 + SHORT_CYC);
    countLevel(1'b1, 10000, n);

    // R5 SCL low during SDA fall
    repeat (99) @(negedge clk);
    sclIn = 1'b0;
    repeat (100) @(negedge clk);
    sdaIn = 1'b0;
    repeat (50) @(negedge clk);
    sclIn = 1'b1;
    repeat (50) @(negedge clk);
    sdaIn = 1'b1;
    countLevel(1'b0, 10000, n);
    check("R5 fall with SCL low", 299 + n, SHORT_CYC);
    countLevel(1'b1, 10000, n);

    // R5 SCL rising together with SDA fall
    repeat (99) @(negedge clk);
    sclIn = 1'b0;
    repeat (100) @(negedge clk);
    sclIn = 1'b1;
    sdaIn = 1'b0;
    repeat (50) @(negedge clk);
    sdaIn = 1'b1;
    countLevel(1'b0, 10000, n);
    check("R5 simultaneous SCL rise", 249 + n, SHORT_CYC);
    countLevel(1'b1, 10000, n);

    // R10 nonvolatile write across reset
    nvWrReq = 1'b1;
    @(negedge clk);
    nvWrReq = 1'b0;
    check("R10 write starts when running", nvWrBusy, 1);
    supplyOk = 1'b0;
    @(negedge clk);
    check("R2 reset during write", resetOut, 1);
    repeat (5) @(negedge clk);
    check("R10 write survives reset", nvWrBusy, 1);
    nvWrDone = 1'b1;
    @(negedge clk);
    nvWrDone = 1'b0;
    check("R10 write completes", nvWrBusy, 0);
    nvWrReq = 1'b1;
    repeat (3) @(negedge clk);
    nvWrReq = 1'b0;
    check("R10 no start in reset", nvWrBusy, 0);
    supplyOk = 1'b1;
    waitLow();
    nvWrReq = 1'b1;
    @(negedge clk);
    nvWrReq = 1'b0;
    check("R10 start after release", nvWrBusy, 1);
    nvWrDone = 1'b1;
    @(negedge clk);
    nvWrDone = 1'b0;
    check("R10 second completion", nvWrBusy, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule